// File: doc/BRIEF.md
# UART Receive Holding Queue

This block is the small elastic store between a UART receive deserializer and the register interface that software reads. The deserializer offers received bytes and line-break events. The block keeps up to four bytes in arrival order and presents the oldest byte whenever the data register is read. It raises the ready, full and break-change flags that feed the status and interrupt logic.

The receive side is told through `canAccept` whether it may hand over a byte. That happens only while the receiver is enabled and the queue has room. A break does not wait for room: it stores a zero byte, and when the queue is already full that zero takes the place of the newest byte. A flush empties the queue in one cycle. It is used for the receiver-reset command.

Top module: `rx_hold_fifo`

## Requirements
- R1: Bytes are returned in the order they were stored, and up to four bytes are held at once.
- R2: `rxReady` is 1 exactly while at least one byte is held; `fifoFull` is 1 exactly while four bytes are held.
- R3: While `popStrobe` is high and the queue is not empty, `popData` shows the oldest byte in that same cycle, and that byte is removed at the clock edge.
- R4: A pop on an empty queue shows 0x00 on `popData` and changes neither the contents nor any flag.
- R5: `canAccept` is 1 only when `rxEnable` is 1 and `fifoFull` is 0. A `pushValid` in a cycle where `canAccept` is 0 is ignored.
- R6: A `breakEvent` stores a 0x00 byte whatever `rxEnable` is, and sets `breakDelta`. `breakDelta` stays set until `breakClear`. If a break and a clear arrive in the same cycle, the flag is set.
- R7: A `breakEvent` while four bytes are held and no pop happens overwrites the newest byte with 0x00. The count stays at four.
- R8: A pop and an accepted push in the same cycle leave the count unchanged and keep the arrival order.
- R9: `flush` empties the queue and clears `rxReady` and `fifoFull` at the next edge. It overrides any push or pop in the same cycle and leaves `breakDelta` alone.
- R10: After reset the queue is empty, all flags are 0 and `popData` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnable | input | 1 | Receiver enabled |
| pushValid | input | 1 | Received byte offered |
| pushData | input | DATA_W | Received byte |
| breakEvent | input | 1 | Line break detected (single-cycle) |
| popStrobe | input | 1 | Data register read |
| flush | input | 1 | Receiver reset: empty the queue |
| breakClear | input | 1 | Clear the break-change flag |
| popData | output | DATA_W | Oldest byte, or 0x00 when empty |
| rxReady | output | 1 | At least one byte held |
| fifoFull | output | 1 | Four bytes held |
| breakDelta | output | 1 | Break seen since last clear |
| canAccept | output | 1 | Receive side may deliver a byte |

## Verification
The checker looks at every cycle for the rules that are local in time. After a flush both flags are low. After a break `breakDelta` and `rxReady` are high. Full always implies ready. An empty pop reads zero, leaves the flags unchanged, and acceptance is never offered while full or disabled. Byte ordering, the overwrite of the newest entry, the refusal of pushes while full and the balanced push-with-pop cycle depend on the data held over several cycles. Only the bench's directed sequences show these, because they compare the popped stream with the expected one.

// File: rtl/rx_hold_pkg.sv
package rx_hold_pkg;
  typedef struct packed {
    logic push;       // append at tail, advance
    logic overwrite;  // rewrite newest entry in place
    logic pop;        // drop head
    logic flush;      // empty everything
    logic wrZero;     // written byte is 0x00 (break)
  } qStrobe_t;
endpackage

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl
  import rx_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxEnable,
  input  logic     pushValid,
  input  logic     breakEvent,
  input  logic     popStrobe,
  input  logic     flush,
  input  logic     breakClear,
  input  logic     isEmpty,
  input  logic     isFull,
  output qStrobe_t strobes,
  output logic     breakDelta,
  output logic     canAccept
);
  logic dataTake;
  logic anyWrite;

  assign canAccept = rxEnable && !isFull;
  assign dataTake  = pushValid && canAccept;
  assign anyWrite  = breakEvent || dataTake;

  always_comb begin
    strobes = '0;
    if (flush) begin
      strobes.flush = 1'b1;
    end else begin
      strobes.pop    = popStrobe && !isEmpty;
      strobes.wrZero = breakEvent;
      if (anyWrite) begin
        if (isFull && !strobes.pop) strobes.overwrite = 1'b1;
        else                        strobes.push      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           breakDelta <= 1'b0;
    else if (breakEvent) breakDelta <= 1'b1;
    else if (breakClear) breakDelta <= 1'b0;
  end
endmodule

// File: rtl/rx_hold_store.sv
module rx_hold_store
  import rx_hold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobes,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] headData,
  output logic              isEmpty,
  output logic              isFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  headPtr, tailPtr, newestPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] wrData;
  logic              wrEn;

  function automatic logic [PTR_W-1:0] incPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign newestPtr = (tailPtr == '0) ? LAST_IDX : tailPtr - 1'b1;
  assign wrPtr     = strobes.overwrite ? newestPtr : tailPtr;
  assign wrEn      = strobes.push || strobes.overwrite;
  assign wrData    = strobes.wrZero ? '0 : pushData;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wrEn && wrPtr == PTR_W'(i)) slot[i] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else if (strobes.flush) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strobes.pop)  headPtr <= incPtr(headPtr);
      if (strobes.push) tailPtr <= incPtr(tailPtr);
      if (strobes.push && !strobes.pop)      count <= count + 1'b1;
      else if (strobes.pop && !strobes.push) count <= count - 1'b1;
    end
  end

  assign isEmpty  = (count == '0);
  assign isFull   = (count == FULL_CNT);
  assign headData = isEmpty ? '0 : slot[headPtr];
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
  import rx_hold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              breakEvent,
  input  logic              popStrobe,
  input  logic              flush,
  input  logic              breakClear,
  output logic [DATA_W-1:0] popData,
  output logic              rxReady,
  output logic              fifoFull,
  output logic              breakDelta,
  output logic              canAccept
);
  qStrobe_t strobes;
  logic     isEmpty, isFull;

  rx_hold_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .pushValid(pushValid),
    .breakEvent(breakEvent), .popStrobe(popStrobe), .flush(flush),
    .breakClear(breakClear), .isEmpty(isEmpty), .isFull(isFull),
    .strobes(strobes), .breakDelta(breakDelta), .canAccept(canAccept)
  );

  rx_hold_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pushData(pushData),
    .headData(popData), .isEmpty(isEmpty), .isFull(isFull)
  );

  assign rxReady  = !isEmpty;
  assign fifoFull = isFull;
endmodule

// File: rtl/rx_hold_fifo_chk.sv
module rx_hold_fifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              pushValid,
  input logic [DATA_W-1:0] pushData,
  input logic              breakEvent,
  input logic              popStrobe,
  input logic              flush,
  input logic              breakClear,
  input logic [DATA_W-1:0] popData,
  input logic              rxReady,
  input logic              fifoFull,
  input logic              breakDelta,
  input logic              canAccept
);
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !rxReady && !fifoFull);

  // R6
  break_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakEvent |=> breakDelta);

  // R6
  break_stores_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (breakEvent && !flush) |=> rxReady);

  // R2
  full_implies_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> rxReady);

  // R4
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && !rxReady) |-> popData == '0);

  // R4
  empty_pop_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && !rxReady && !breakEvent && !(pushValid && canAccept) && !flush)
      |=> !rxReady && !fifoFull);

  // R5
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    canAccept |-> rxEnable && !fifoFull);

  // R7
  overwrite_keeps_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && breakEvent && !popStrobe && !flush) |=> fifoFull);
endmodule

bind rx_hold_fifo rx_hold_fifo_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/rx_hold_fifo_tb_top.sv
module rx_hold_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0, pushValid = 1'b0, breakEvent = 1'b0;
  logic       popStrobe = 1'b0, flush = 1'b0, breakClear = 1'b0;
  logic [7:0] pushData = '0;
  logic [7:0] popData;
  logic       rxReady, fifoFull, breakDelta, canAccept;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_hold_fifo dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .pushValid(pushValid),
    .pushData(pushData), .breakEvent(breakEvent), .popStrobe(popStrobe),
    .flush(flush), .breakClear(breakClear), .popData(popData),
    .rxReady(rxReady), .fifoFull(fifoFull), .breakDelta(breakDelta),
    .canAccept(canAccept)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pushByte(input logic [7:0] d);
    pushValid = 1'b1; pushData = d;
    cyc();
    pushValid = 1'b0;
  endtask

  task automatic popExpect(input string req, input logic [7:0] exp);
    popStrobe = 1'b1;
    #2 chk(req, popData, exp);
    cyc();
    popStrobe = 1'b0;
  endtask

  task automatic sendBreak();
    breakEvent = 1'b1;
    cyc();
    breakEvent = 1'b0;
  endtask

  task automatic doFlush();
    flush = 1'b1;
    cyc();
    flush = 1'b0;
  endtask

  task automatic fill4();
    pushByte(8'h11); pushByte(8'h22); pushByte(8'h33); pushByte(8'h44);
  endtask

  task automatic t_reset();
    chk("R10 ready", rxReady, 0);
    chk("R10 full", fifoFull, 0);
    chk("R10 delta", breakDelta, 0);
    chk("R10 accept", canAccept, 0);
    chk("R10 data", popData, 0);
  endtask

  task automatic t_accept();
    pushByte(8'h99);
    chk("R5 disabled push ignored", rxReady, 0);
    rxEnable = 1'b1;
    #1 chk("R5 accept when enabled", canAccept, 1);
  endtask

  task automatic t_order();
    pushByte(8'hA1);
    chk("R2 ready after push", rxReady, 1);
    pushByte(8'hB2); pushByte(8'hC3);
    chk("R2 not full at three", fifoFull, 0);
    pushByte(8'hD4);
    chk("R2 full at four", fifoFull, 1);
    chk("R5 no accept when full", canAccept, 0);
    pushByte(8'h55);
    popExpect("R1 first", 8'hA1);
    chk("R2 pop clears full", fifoFull, 0);
    popExpect("R1 second", 8'hB2);
    popExpect("R1 third", 8'hC3);
    popExpect("R5 full push ignored", 8'hD4);
    chk("R3 ready clears when empty", rxReady, 0);
  endtask

  task automatic t_emptyPop();
    popExpect("R4 empty pop zero", 8'h00);
    chk("R4 still empty", rxReady, 0);
    pushByte(8'h3C);
    popExpect("R4 state unchanged", 8'h3C);
  endtask

  task automatic t_breakOverwrite();
    fill4();
    sendBreak();
    chk("R7 count stays full", fifoFull, 1);
    chk("R6 delta set", breakDelta, 1);
    popExpect("R7 head kept", 8'h11);
    popExpect("R7 second kept", 8'h22);
    popExpect("R7 third kept", 8'h33);
    popExpect("R7 newest replaced", 8'h00);
    chk("R7 empty after four", rxReady, 0);
    breakClear = 1'b1; breakEvent = 1'b1;
    cyc();
    breakClear = 1'b0; breakEvent = 1'b0;
    chk("R6 set wins over clear", breakDelta, 1);
    breakClear = 1'b1;
    cyc();
    breakClear = 1'b0;
    chk("R6 clear", breakDelta, 0);
    popExpect("R6 break byte zero", 8'h00);
  endtask

  task automatic t_breakDisabled();
    rxEnable = 1'b0;
    sendBreak();
    chk("R6 break stored while disabled", rxReady, 1);
    popExpect("R6 break byte", 8'h00);
    rxEnable = 1'b1;
    breakClear = 1'b1; cyc(); breakClear = 1'b0;
  endtask

  task automatic t_pushPop();
    pushByte(8'h61); pushByte(8'h62);
    pushValid = 1'b1; pushData = 8'h77; popStrobe = 1'b1;
    #2 chk("R8 pop data", popData, 8'h61);
    cyc();
    pushValid = 1'b0; popStrobe = 1'b0;
    popExpect("R8 order 1", 8'h62);
    popExpect("R8 order 2", 8'h77);
    chk("R8 count kept", rxReady, 0);
  endtask

  task automatic t_flush();
    fill4();
    flush = 1'b1; pushValid = 1'b1; pushData = 8'hEE; popStrobe = 1'b1;
    cyc();
    flush = 1'b0; pushValid = 1'b0; popStrobe = 1'b0;
    chk("R9 ready cleared", rxReady, 0);
    chk("R9 full cleared", fifoFull, 0);
    popExpect("R9 empty after flush", 8'h00);
    sendBreak();
    doFlush();
    chk("R9 delta untouched", breakDelta, 1);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_accept();
    t_order();
    t_emptyPop();
    t_breakOverwrite();
    t_breakDisabled();
    t_pushPop();
    t_flush();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule